// File: doc/BRIEF.md
# Non-Blocking Cache Miss Tracker

This block keeps the bookkeeping for the misses a non-blocking data cache has in flight. The cache hands it each miss as a block address, the word offset wanted inside that block and a requester tag. The tracker compares the block against every busy entry. When a miss to that block is already pending, the miss is appended to that entry's target list and nothing new goes to memory. Otherwise a free entry is claimed and a fill request is raised toward lower memory, carrying the block address and the entry index.

Memory answers with a fill that names the entry index. Fills may therefore come back in any order. The tracker latches the returned line. It then replays the entry's targets one per cycle, in the order they were recorded, and gives each requester its word. The entry is released in the cycle after its last reply. The tracker also drives a single stall line. The line is high whenever all entries are busy, which blocks hits as well as misses. It is also high when the presented miss cannot be merged, either because the matching entry's target list is full or because that entry is replaying. While space remains, hits keep flowing under outstanding misses.

Each entry runs a four-state machine. FREE goes to WAIT_ISSUE on allocation. WAIT_ISSUE goes to WAIT_FILL when memory accepts the request. WAIT_FILL goes to REPLAY when the fill is taken. REPLAY goes back to FREE on release. The replay engine has two states. IDLE goes to REPLAY when a fill is accepted, and REPLAY returns to IDLE after the last target is answered.

Top module: `mshr_tracker`

## Requirements
- R1: After reset, stall, mem_req_valid and resp_valid are low and fill_ready is high.
- R2: A miss accepted (miss_valid high, stall low) to a block with no busy entry claims the lowest-numbered free entry. From the next cycle, mem_req_valid is high with that block on mem_req_blk and the entry number on mem_req_id. Both values hold until mem_req_ready is seen high.
- R3: An accepted miss to a block whose entry is waiting for issue or for fill sends no further memory request. The miss is recorded as one more target of that entry.
- R4: A fill is accepted when fill_valid and fill_ready are both high. From the next cycle, the targets of entry fill_id are answered one per cycle, in arrival order. Each answer has resp_valid high, that target's tag on resp_rtag, and word k of the line on resp_word, where word k sits at fill_data[k*WORD_W +: WORD_W] and k is the target's offset. Every accepted miss is answered exactly once.
- R5: fill_ready is low while a replay runs. In the cycle after the last answer, resp_valid is low, fill_ready is high and the entry is free again, so it can be claimed.
- R6: While every entry is busy, stall is high whether or not a miss is presented. Stall drops in the cycle after an entry is released.
- R7: While at least one entry is free and no unmergeable miss is presented, stall is low.
- R8: A miss to a block whose entry already holds N_TGT targets raises stall and is not recorded.
- R9: A miss to a block whose entry is replaying raises stall. A miss to any other block in that cycle is not held back.
- R10: Fills may come back in any order, and each replay uses the entry named by fill_id.
- R11: When several entries wait for issue and no request is being held, the lowest-numbered one is offered first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_valid | input | 1 | A miss is presented |
| miss_blk | input | BLK_W | Block address of the miss |
| miss_off | input | OFF_W | Word offset inside the block |
| miss_rtag | input | RTAG_W | Requester tag returned with the answer |
| stall | output | 1 | Cache must hold both hits and misses |
| mem_req_valid | output | 1 | Fill request to lower memory |
| mem_req_ready | input | 1 | Lower memory takes the request |
| mem_req_blk | output | BLK_W | Block address requested |
| mem_req_id | output | $clog2(N_ENT) | Entry number requesting |
| fill_valid | input | 1 | Fill line returned |
| fill_ready | output | 1 | Tracker can accept a fill |
| fill_id | input | $clog2(N_ENT) | Entry the fill belongs to |
| fill_data | input | WORD_W<<OFF_W | Whole block, word k at bits k*WORD_W |
| resp_valid | output | 1 | A target answer is presented |
| resp_rtag | output | RTAG_W | Tag of the answered target |
| resp_word | output | WORD_W | Word the target asked for |

## Verification
The embedded properties watch the per-cycle rules on every cycle. They check that at most one busy entry matches a block, that a refused memory request keeps its block and entry number, that a full tracker stalls and a non-full idle one does not, that appends and allocations land only on entries in the right state, that an answer follows a taken fill at once, and that the replay index stays inside the target list. Only the bench scenarios can show the end-to-end properties. These are: replies come in recorded order with the right words, merged misses share a single memory request, a freed entry is reused at once, fills returned out of order reach the right requesters, and over a long randomised run every accepted miss is answered exactly once.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

    typedef enum logic [1:0] {
        E_FREE       = 2'd0,
        E_WAIT_ISSUE = 2'd1,
        E_WAIT_FILL  = 2'd2,
        E_REPLAY     = 2'd3
    } ent_state_e;

    typedef enum logic {
        D_IDLE   = 1'b0,
        D_REPLAY = 1'b1
    } drn_state_e;

endpackage

// File: rtl/mshr_entry.sv
module mshr_entry
    import mshr_pkg::*;
#(
    parameter int BLK_W  = 26,
    parameter int OFF_W  = 2,
    parameter int RTAG_W = 6,
    parameter int N_TGT  = 4,
    parameter int CNT_W  = $clog2(N_TGT + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_i,
    input  logic                    append_i,
    input  logic [BLK_W-1:0]        req_blk_i,
    input  logic [OFF_W-1:0]        req_off_i,
    input  logic [RTAG_W-1:0]       req_rtag_i,
    input  logic                    issue_ack_i,
    input  logic                    fill_take_i,
    input  logic                    release_i,
    output ent_state_e              state_o,
    output logic [BLK_W-1:0]        blk_o,
    output logic [CNT_W-1:0]        cnt_o,
    output logic [N_TGT*OFF_W-1:0]  tgt_off_o,
    output logic [N_TGT*RTAG_W-1:0] tgt_rtag_o
);

    ent_state_e       st_q, st_d;
    logic [BLK_W-1:0] blk_q;
    logic [CNT_W-1:0] cnt_q;
    logic             claim;
    logic             merging;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= E_FREE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            E_FREE:       if (alloc_i)     st_d = E_WAIT_ISSUE;
            E_WAIT_ISSUE: if (issue_ack_i) st_d = E_WAIT_FILL;
            E_WAIT_FILL:  if (fill_take_i) st_d = E_REPLAY;
            E_REPLAY:     if (release_i)   st_d = E_FREE;
            default:                       st_d = E_FREE;
        endcase
    end

    // outputs / qualified strobes
    always_comb begin
        claim   = 1'b0;
        merging = 1'b0;
        unique case (st_q)
            E_FREE:       claim   = alloc_i;
            E_WAIT_ISSUE: merging = append_i;
            E_WAIT_FILL:  merging = append_i;
            E_REPLAY:     merging = 1'b0;
            default:      merging = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q <= '0;
            cnt_q <= '0;
        end else if (claim) begin
            blk_q <= req_blk_i;
            cnt_q <= CNT_W'(1);
        end else if (merging) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else if (release_i && st_q == E_REPLAY) begin
            cnt_q <= '0;
        end
    end

    // target slots: slot 0 filled on claim, slot n on the n-th merge
    for (genvar s = 0; s < N_TGT; s++) begin : g_slot
        logic [OFF_W-1:0]  off_r;
        logic [RTAG_W-1:0] rtag_r;
        logic              wr;
        assign wr = (claim && s == 0) || (merging && cnt_q == CNT_W'(s));
        always_ff @(posedge clk) begin
            if (wr) begin
                off_r  <= req_off_i;
                rtag_r <= req_rtag_i;
            end
        end
        assign tgt_off_o[s*OFF_W +: OFF_W]    = off_r;
        assign tgt_rtag_o[s*RTAG_W +: RTAG_W] = rtag_r;
    end

    assign state_o = st_q;
    assign blk_o   = blk_q;
    assign cnt_o   = cnt_q;

    a_r2_alloc_only_free: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> st_q == E_FREE);

    a_r3_append_with_room: assert property (@(posedge clk) disable iff (!rst_n)
        append_i |-> (cnt_q < CNT_W'(N_TGT)) &&
                     (st_q == E_WAIT_ISSUE || st_q == E_WAIT_FILL));

    a_r4_fill_when_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        fill_take_i |-> st_q == E_WAIT_FILL);

    a_r5_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && st_q == E_REPLAY) |=> st_q == E_FREE && cnt_q == '0);

    a_r8_busy_has_target: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != E_FREE) |-> cnt_q != '0);

endmodule

// File: rtl/mshr_drain.sv
module mshr_drain
    import mshr_pkg::*;
#(
    parameter int N_ENT  = 4,
    parameter int N_TGT  = 4,
    parameter int OFF_W  = 2,
    parameter int RTAG_W = 6,
    parameter int WORD_W = 32,
    parameter int ID_W   = $clog2(N_ENT),
    parameter int CNT_W  = $clog2(N_TGT + 1),
    parameter int IDX_W  = $clog2(N_TGT),
    parameter int LINE_W = WORD_W << OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid_i,
    input  logic [ID_W-1:0]   fill_id_i,
    input  logic [LINE_W-1:0] fill_data_i,
    input  logic [CNT_W-1:0]  sel_cnt_i,
    input  logic [OFF_W-1:0]  sel_off_i,
    input  logic [RTAG_W-1:0] sel_rtag_i,
    output logic              fill_ready_o,
    output logic              take_o,
    output logic [ID_W-1:0]   cur_id_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              release_o,
    output logic              resp_valid_o,
    output logic [RTAG_W-1:0] resp_rtag_o,
    output logic [WORD_W-1:0] resp_word_o
);

    drn_state_e        st_q, st_d;
    logic [ID_W-1:0]   id_q;
    logic [IDX_W-1:0]  idx_q;
    logic [LINE_W-1:0] data_q;
    logic              last;

    assign last = (CNT_W'(idx_q) + CNT_W'(1)) == sel_cnt_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= D_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            D_IDLE:   if (fill_valid_i) st_d = D_REPLAY;
            D_REPLAY: if (last)         st_d = D_IDLE;
            default:                    st_d = D_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fill_ready_o = 1'b0;
        resp_valid_o = 1'b0;
        unique case (st_q)
            D_IDLE:   fill_ready_o = 1'b1;
            D_REPLAY: resp_valid_o = 1'b1;
            default:  fill_ready_o = 1'b0;
        endcase
    end

    assign take_o      = fill_ready_o & fill_valid_i;
    assign release_o   = resp_valid_o & last;
    assign resp_rtag_o = sel_rtag_i;
    assign resp_word_o = data_q[int'(sel_off_i)*WORD_W +: WORD_W];
    assign cur_id_o    = id_q;
    assign idx_o       = idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q   <= '0;
            idx_q  <= '0;
            data_q <= '0;
        end else if (take_o) begin
            id_q   <= fill_id_i;
            idx_q  <= '0;
            data_q <= fill_data_i;
        end else if (resp_valid_o && !last) begin
            idx_q  <= idx_q + IDX_W'(1);
        end
    end

    a_r4_first_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid_i && fill_ready_o) |=> resp_valid_o && idx_q == '0);

    a_r4_idx_within_list: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o |-> CNT_W'(idx_q) < sel_cnt_i);

    a_r5_ready_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> fill_ready_o && !resp_valid_o);

endmodule

// File: rtl/mshr_tracker.sv
module mshr_tracker
    import mshr_pkg::*;
#(
    parameter int N_ENT  = 4,
    parameter int N_TGT  = 4,
    parameter int BLK_W  = 26,
    parameter int OFF_W  = 2,
    parameter int RTAG_W = 6,
    parameter int WORD_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        miss_valid,
    input  logic [BLK_W-1:0]            miss_blk,
    input  logic [OFF_W-1:0]            miss_off,
    input  logic [RTAG_W-1:0]           miss_rtag,
    output logic                        stall,
    output logic                        mem_req_valid,
    input  logic                        mem_req_ready,
    output logic [BLK_W-1:0]            mem_req_blk,
    output logic [$clog2(N_ENT)-1:0]    mem_req_id,
    input  logic                        fill_valid,
    output logic                        fill_ready,
    input  logic [$clog2(N_ENT)-1:0]    fill_id,
    input  logic [(WORD_W<<OFF_W)-1:0]  fill_data,
    output logic                        resp_valid,
    output logic [RTAG_W-1:0]           resp_rtag,
    output logic [WORD_W-1:0]           resp_word
);

    localparam int ID_W   = $clog2(N_ENT);
    localparam int CNT_W  = $clog2(N_TGT + 1);
    localparam int IDX_W  = $clog2(N_TGT);
    localparam int LINE_W = WORD_W << OFF_W;

    ent_state_e               ent_st   [N_ENT];
    logic [BLK_W-1:0]         ent_blk  [N_ENT];
    logic [CNT_W-1:0]         ent_cnt  [N_ENT];
    logic [N_TGT*OFF_W-1:0]   ent_off  [N_ENT];
    logic [N_TGT*RTAG_W-1:0]  ent_rtag [N_ENT];

    logic [N_ENT-1:0] busy, match, match_full, match_play, pend;
    logic             all_busy, conflict, accept, do_alloc, do_append;
    logic [ID_W-1:0]  alloc_id, pick_id, hold_id_q;
    logic             hold_q;

    logic             take, rel;
    logic [ID_W-1:0]  cur_id;
    logic [IDX_W-1:0] cur_idx;
    logic [CNT_W-1:0] sel_cnt;
    logic [OFF_W-1:0] sel_off;
    logic [RTAG_W-1:0] sel_rtag;

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        assign busy[i]       = ent_st[i] != E_FREE;
        assign match[i]      = miss_valid && busy[i] && ent_blk[i] == miss_blk;
        assign match_full[i] = match[i] && ent_cnt[i] == CNT_W'(N_TGT);
        assign match_play[i] = match[i] && ent_st[i] == E_REPLAY;
        assign pend[i]       = ent_st[i] == E_WAIT_ISSUE;

        mshr_entry #(
            .BLK_W (BLK_W),
            .OFF_W (OFF_W),
            .RTAG_W(RTAG_W),
            .N_TGT (N_TGT),
            .CNT_W (CNT_W)
        ) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_i    (do_alloc && alloc_id == ID_W'(i)),
            .append_i   (do_append && match[i]),
            .req_blk_i  (miss_blk),
            .req_off_i  (miss_off),
            .req_rtag_i (miss_rtag),
            .issue_ack_i(mem_req_valid && mem_req_ready && mem_req_id == ID_W'(i)),
            .fill_take_i(take && fill_id == ID_W'(i)),
            .release_i  (rel && cur_id == ID_W'(i)),
            .state_o    (ent_st[i]),
            .blk_o      (ent_blk[i]),
            .cnt_o      (ent_cnt[i]),
            .tgt_off_o  (ent_off[i]),
            .tgt_rtag_o (ent_rtag[i])
        );
    end

    // lookup, stall and accept
    assign all_busy  = &busy;
    assign conflict  = |(match_full | match_play);
    assign stall     = all_busy | conflict;
    assign accept    = miss_valid & ~stall;
    assign do_alloc  = accept & ~(|match);
    assign do_append = accept & (|match);

    // lowest free entry and lowest pending entry
    always_comb begin
        alloc_id = '0;
        pick_id  = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!busy[i]) alloc_id = ID_W'(i);
            if (pend[i])  pick_id  = ID_W'(i);
        end
    end

    // issue: an offered request keeps its entry until taken
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q    <= 1'b0;
            hold_id_q <= '0;
        end else begin
            hold_q    <= mem_req_valid & ~mem_req_ready;
            hold_id_q <= mem_req_id;
        end
    end

    assign mem_req_valid = |pend;
    assign mem_req_id    = hold_q ? hold_id_q : pick_id;
    assign mem_req_blk   = ent_blk[mem_req_id];

    // replay path
    assign sel_cnt  = ent_cnt[cur_id];
    assign sel_off  = ent_off[cur_id][int'(cur_idx)*OFF_W +: OFF_W];
    assign sel_rtag = ent_rtag[cur_id][int'(cur_idx)*RTAG_W +: RTAG_W];

    mshr_drain #(
        .N_ENT (N_ENT),
        .N_TGT (N_TGT),
        .OFF_W (OFF_W),
        .RTAG_W(RTAG_W),
        .WORD_W(WORD_W),
        .ID_W  (ID_W),
        .CNT_W (CNT_W),
        .IDX_W (IDX_W),
        .LINE_W(LINE_W)
    ) u_drain (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill_valid_i(fill_valid),
        .fill_id_i   (fill_id),
        .fill_data_i (fill_data),
        .sel_cnt_i   (sel_cnt),
        .sel_off_i   (sel_off),
        .sel_rtag_i  (sel_rtag),
        .fill_ready_o(fill_ready),
        .take_o      (take),
        .cur_id_o    (cur_id),
        .idx_o       (cur_idx),
        .release_o   (rel),
        .resp_valid_o(resp_valid),
        .resp_rtag_o (resp_rtag),
        .resp_word_o (resp_word)
    );

    a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    a_r2_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            mem_req_valid && $stable(mem_req_id) && $stable(mem_req_blk));

    a_r6_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy) |-> stall);

    a_r7_hit_under_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&busy) && !miss_valid) |-> !stall);

endmodule

// File: tb/tb_mshr_tracker.sv
module tb_mshr_tracker;

    localparam int NE = 4;
    localparam int NT = 4;
    localparam int BW = 26;
    localparam int OW = 2;
    localparam int TW = 6;
    localparam int WW = 32;
    localparam int IW = $clog2(NE);
    localparam int LW = WW << OW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [BW-1:0] miss_blk = '0;
    logic [OW-1:0] miss_off = '0;
    logic [TW-1:0] miss_rtag = '0;
    logic          stall;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [BW-1:0] mem_req_blk;
    logic [IW-1:0] mem_req_id;
    logic          fill_valid = 1'b0;
    logic          fill_ready;
    logic [IW-1:0] fill_id = '0;
    logic [LW-1:0] fill_data = '0;
    logic          resp_valid;
    logic [TW-1:0] resp_rtag;
    logic [WW-1:0] resp_word;

    always #5 clk = ~clk;

    mshr_tracker #(.N_ENT(NE), .N_TGT(NT), .BLK_W(BW), .OFF_W(OW),
                   .RTAG_W(TW), .WORD_W(WW)) dut (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_blk(miss_blk), .miss_off(miss_off),
        .miss_rtag(miss_rtag), .stall(stall),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_blk(mem_req_blk), .mem_req_id(mem_req_id),
        .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_id(fill_id),
        .fill_data(fill_data),
        .resp_valid(resp_valid), .resp_rtag(resp_rtag), .resp_word(resp_word)
    );

    int tests = 0, fails = 0;
    int pend_cnt = 0, resp_cnt = 0, hs_cnt = 0;
    bit done = 0;
    bit            exp_pend [64];
    logic [BW-1:0] exp_blk  [64];
    logic [OW-1:0] exp_off  [64];
    bit            id_act   [NE];
    logic [BW-1:0] id_blk   [NE];
    logic [TW-1:0] next_tag = '0;
    bit            dup;
    logic [BW-1:0] pool [6];

    function automatic logic [WW-1:0] wf(input logic [BW-1:0] b, input logic [OW-1:0] k);
        return {4'hA, b, k};
    endfunction

    function automatic logic [LW-1:0] line(input logic [BW-1:0] b);
        logic [LW-1:0] l;
        for (int k = 0; k < (1 << OW); k++) l[k*WW +: WW] = wf(b, OW'(k));
        return l;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // scoreboard, sampled just before each rising edge
    initial forever begin
        @(negedge clk); #4;
        if (rst_n) begin
            if (resp_valid) begin
                chk(exp_pend[resp_rtag], "R4 answer for an outstanding tag", resp_rtag, resp_rtag);
                chk(resp_word == wf(exp_blk[resp_rtag], exp_off[resp_rtag]),
                    "R4 answer word", resp_word, wf(exp_blk[resp_rtag], exp_off[resp_rtag]));
                if (exp_pend[resp_rtag]) pend_cnt--;
                exp_pend[resp_rtag] = 0;
                resp_cnt++;
            end
            if (miss_valid && !stall) begin
                exp_pend[miss_rtag] = 1;
                exp_blk[miss_rtag]  = miss_blk;
                exp_off[miss_rtag]  = miss_off;
                pend_cnt++;
                next_tag++;
            end
            if (mem_req_valid && mem_req_ready) begin
                dup = 0;
                for (int i = 0; i < NE; i++)
                    if (id_act[i] && id_blk[i] == mem_req_blk) dup = 1;
                chk(!dup && !id_act[mem_req_id], "R3 one request per block in flight",
                    mem_req_blk, 0);
                id_act[mem_req_id] = 1;
                id_blk[mem_req_id] = mem_req_blk;
                hs_cnt++;
            end
            if (fill_valid && fill_ready) id_act[fill_id] = 0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        summary();
    end

    task automatic go();  @(negedge clk); #1; endtask
    task automatic look(); #2; endtask

    task automatic miss(input logic [BW-1:0] b, input logic [OW-1:0] o, input logic [TW-1:0] t);
        miss_valid = 1; miss_blk = b; miss_off = o; miss_rtag = t;
    endtask

    task automatic fill(input int id);
        fill_valid = 1; fill_id = IW'(id); fill_data = line(id_blk[id]);
    endtask

    task automatic drain_all();
        for (int c = 0; c < 400; c++) begin
            go();
            miss_valid = 0; mem_req_ready = 1; fill_valid = 0;
            for (int i = 0; i < NE; i++) if (id_act[i] && !fill_valid) fill(i);
            look();
            if (pend_cnt == 0 && !mem_req_valid && !resp_valid) break;
        end
        go(); miss_valid = 0; mem_req_ready = 0; fill_valid = 0; look();
    endtask

    int h0, r0;
    logic [BW-1:0] A = 26'h0A0A, B = 26'h0B01, C = 26'h0C02, D = 26'h0D03,
                   E = 26'h0E04, F = 26'h0F05, G = 26'h1006, H = 26'h1107,
                   J = 26'h1208, K = 26'h1309, L = 26'h140A;

    initial begin
        void'($urandom(32'h5EED));
        pool[0] = 26'h2000; pool[1] = 26'h2001; pool[2] = 26'h2002;
        pool[3] = 26'h2003; pool[4] = 26'h2004; pool[5] = 26'h2005;
        repeat (3) go();
        rst_n = 1;
        look();
        chk(!stall && !mem_req_valid && !resp_valid && fill_ready, "R1 reset state",
            {stall, mem_req_valid, resp_valid, fill_ready}, 4'b0001);

        // merge three misses into one entry, replay in order, reuse
        go(); miss(A, 2'd1, 6'd1); look();
        chk(!stall, "R7 stall low with free entries", stall, 0);
        go(); miss(A, 2'd3, 6'd2); look();
        chk(mem_req_valid && mem_req_id == 0 && mem_req_blk == A, "R2 request for first miss",
            {mem_req_valid, mem_req_id}, 3'b100);
        go(); miss(A, 2'd0, 6'd3); look();
        chk(mem_req_valid && mem_req_blk == A, "R2 request held while refused", mem_req_valid, 1);
        h0 = hs_cnt;
        go(); miss_valid = 0; mem_req_ready = 1; look();
        go(); mem_req_ready = 0; look();
        chk(!mem_req_valid && hs_cnt == h0 + 1, "R3 single request for merged misses",
            hs_cnt - h0, 1);
        go(); fill(0); look();
        chk(fill_ready, "R4 fill accepted when idle", fill_ready, 1);
        go(); fill_valid = 0; look();
        chk(resp_valid && resp_rtag == 1 && resp_word == wf(A, 2'd1), "R4 first target", resp_rtag, 1);
        go(); look();
        chk(resp_valid && resp_rtag == 2 && !fill_ready, "R4 second target, R5 busy", resp_rtag, 2);
        go(); look();
        chk(resp_valid && resp_rtag == 3 && resp_word == wf(A, 2'd0), "R4 third target", resp_rtag, 3);
        go(); miss(D, 2'd2, 6'd4); look();
        chk(!resp_valid && fill_ready && !stall, "R5 idle after last answer",
            {resp_valid, fill_ready}, 2'b01);
        go(); miss_valid = 0; look();
        chk(mem_req_valid && mem_req_id == 0 && mem_req_blk == D, "R5 freed entry claimed",
            mem_req_id, 0);
        drain_all();

        // R11 priority and R10 out-of-order fill
        go(); miss(B, 2'd0, 6'd10); look();
        go(); miss(C, 2'd1, 6'd11); look();
        go(); miss_valid = 0; look();
        chk(mem_req_valid && mem_req_id == 0, "R11 lowest pending offered", mem_req_id, 0);
        go(); mem_req_ready = 1; look();
        go(); look();
        go(); mem_req_ready = 0; fill(1); look();
        go(); fill_valid = 0; look();
        chk(resp_valid && resp_rtag == 11 && resp_word == wf(C, 2'd1), "R10 later entry filled first",
            resp_rtag, 11);
        drain_all();

        // R6/R7 full tracker
        go(); miss(E, 2'd0, 6'd12); look();
        go(); miss(F, 2'd1, 6'd13); look();
        go(); miss(G, 2'd2, 6'd14); look();
        go(); miss_valid = 0; look();
        chk(!stall, "R7 hits pass with three outstanding", stall, 0);
        go(); miss(H, 2'd3, 6'd15); look();
        chk(!stall, "R7 fourth miss accepted", stall, 0);
        go(); miss_valid = 0; look();
        chk(stall, "R6 full tracker blocks hits", stall, 1);
        go(); miss(E, 2'd2, 6'd16); look();
        chk(stall, "R6 full tracker blocks merge", stall, 1);
        go(); miss_valid = 0; mem_req_ready = 1; look();
        repeat (4) begin go(); look(); end
        go(); mem_req_ready = 0; fill(2); look();
        go(); fill_valid = 0; look();
        go(); look();
        chk(!stall, "R6 stall drops after release", stall, 0);
        drain_all();
        chk(!exp_pend[16], "R6 stalled miss not recorded", exp_pend[16], 0);

        // R8 full target list
        for (int t = 0; t < NT; t++) begin go(); miss(J, OW'(t), TW'(20 + t)); look(); end
        go(); miss(J, 2'd1, 6'd24); look();
        chk(stall, "R8 full target list stalls", stall, 1);
        go(); miss_valid = 0; look();
        r0 = resp_cnt;
        drain_all();
        chk(resp_cnt - r0 == NT && !exp_pend[24], "R8 only four targets answered", resp_cnt - r0, NT);

        // R9 replaying block
        go(); miss(K, 2'd0, 6'd30); look();
        go(); miss(K, 2'd2, 6'd31); look();
        go(); miss(K, 2'd3, 6'd32); look();
        go(); miss_valid = 0; mem_req_ready = 1; look();
        go(); mem_req_ready = 0; fill(0); look();
        go(); fill_valid = 0; miss(K, 2'd1, 6'd33); look();
        chk(resp_valid && stall, "R9 replaying block stalls", stall, 1);
        go(); miss(L, 2'd1, 6'd34); look();
        chk(!stall, "R9 other block proceeds during replay", stall, 0);
        go(); miss_valid = 0; look();
        drain_all();
        chk(!exp_pend[33], "R9 stalled miss not recorded", exp_pend[33], 0);

        // constrained random mix
        for (int c = 0; c < 3000; c++) begin
            go();
            mem_req_ready = ($urandom % 3) != 0;
            if (($urandom % 2) == 1 && !exp_pend[next_tag])
                miss(pool[$urandom % 6], OW'($urandom), next_tag);
            else
                miss_valid = 0;
            fill_valid = 0;
            if (($urandom % 3) == 0) begin
                automatic int k = int'($urandom % NE);
                if (id_act[k]) fill(k);
            end
            look();
        end
        drain_all();
        chk(pend_cnt == 0, "R4 every accepted miss answered once", pend_cnt, 0);
        chk(!stall && fill_ready && !mem_req_valid, "R5 all entries free at end",
            {stall, fill_ready, mem_req_valid}, 3'b010);

        summary();
    end

endmodule